// File: doc/BRIEF.md
# Stipple and Block-Copy Drawing Engine

This block accelerates two simple drawing operations on an 8-bit-per-pixel frame memory. A host issues each operation as one 32-bit write. The window select picks the operation, the byte offset of the write names the destination pixel, and the data word carries the operands. A stipple write paints, in the current fill colour, every pixel whose bit is set in a 32-bit mask. A blit write either copies a run of 1 to 32 pixels from a source index to the destination, or fills that run with the fill colour when the source field holds a reserved code. A third window loads the fill colour register.

The engine handles one pixel per clock through a memory port with separate read and write strobes. The read port has one cycle of latency. A copy therefore overlaps the read of pixel k+1 with the write of pixel k and needs one extra drain cycle at the end. While a command runs, `busy` is high and `cmd_ready` is low, so a command offered in that time waits in place until the engine returns to idle.

The controller is one state machine with these states:
- IDLE: waits for a command.
- STIP: walks the stipple mask.
- FILL: writes the fill run.
- COPY: issues the copy reads.
- DRAIN: completes the final copy write.

Its transitions are:
- IDLE to STIP on an accepted stipple whose mask is not zero.
- IDLE to FILL on an accepted blit with the fill code.
- IDLE to COPY on any other accepted blit.
- STIP to IDLE once no set mask bit remains.
- FILL to IDLE after the last pixel.
- COPY to DRAIN after the last read.
- DRAIN to IDLE.

Colour loads, all-zero stipples and unused-window writes are accepted in IDLE and leave the state unchanged.

Top module: `stip_blit_engine`

## Requirements
- R1: After reset, `busy` is 0, `cmd_ready` is 1, neither memory strobe is active and the fill colour is 0. No memory strobe is active while `busy` is 0.
- R2: The destination pixel index is `cmd_addr` shifted right by 3. The low three address bits are ignored.
- R3: A stipple command (`cmd_sel`=0) tests data bit 31 first, for the destination pixel, and then each lower bit for the next pixel. Set bits write the fill colour. Clear bits leave memory unchanged.
- R4: A stipple command whose data is zero is accepted without raising `busy` and without any memory write.
- R5: A stipple command keeps `busy` high for exactly 32−b cycles, where b is the position of the lowest set mask bit.
- R6: In a blit command (`cmd_sel`=1), data bits 23:0 give the source index, of which the low PIX_W bits address memory. Bits 28:24 give the length minus one. Bits 31:29 are ignored.
- R7: A blit whose source field is 0xFFFFFF writes the fill colour to each pixel of the run and keeps `busy` high for exactly the run length.
- R8: Any other blit copies the run in ascending order, source to destination. Each read is followed by its write one cycle later, and `busy` stays high for the run length plus one. Source and destination runs are assumed not to overlap.
- R9: A write with `cmd_sel`=2 loads the fill colour from data bits 7:0 without raising `busy`.
- R10: While `busy` is 1, `cmd_ready` is 0 and a held command waits. It is accepted on the first cycle `busy` is 0.
- R11: A write with `cmd_sel`=3 is accepted and has no effect on memory or on the fill colour.
- R12: `rd_data` always reads 0.
- R13: Pixel indices increment modulo 2^PIX_W. Writes in consecutive cycles go to consecutive pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write offered |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_sel | input | 2 | Window: 0 stipple, 1 blit, 2 fill colour, 3 unused |
| cmd_addr | input | PIX_W+3 | Byte offset of the write inside the window |
| cmd_wdata | input | 32 | Mask, blit operands or colour |
| rd_data | output | 32 | Read data of the command windows, always zero |
| busy | output | 1 | A drawing command is in progress |
| mem_re | output | 1 | Frame memory read strobe |
| mem_raddr | output | PIX_W | Frame memory read pixel index |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_re |
| mem_we | output | 1 | Frame memory write strobe |
| mem_waddr | output | PIX_W | Frame memory write pixel index |
| mem_wdata | output | 8 | Frame memory write data |

## Verification
A wrong sequencer state shows up at the ports within one command. It appears as a `busy` window that is too long or too short, as a write strobe at a clear mask bit, or as a missing drain write that leaves the last copied pixel stale. A corrupted pointer or counter sends writes to the wrong pixels, so a full comparison of the frame memory against a bench model after every command exposes it before the next command starts. A stale fill colour register shows in the very next stipple or fill.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

    // Command word layout
    localparam int CMD_W      = 32;
    localparam int MASK_W     = 32;
    localparam int SRC_W      = 24;
    localparam int LEN_W      = 5;
    localparam int LEN_LSB    = 24;
    localparam int ADDR_SHIFT = 3;
    localparam logic [SRC_W-1:0] FILL_CODE = '1;

    typedef enum logic [1:0] {
        WIN_STIP  = 2'd0,
        WIN_BLIT  = 2'd1,
        WIN_COLOR = 2'd2,
        WIN_NONE  = 2'd3
    } win_t;

    typedef enum logic [2:0] {
        K_SKIP,
        K_STIP,
        K_FILL,
        K_COPY,
        K_COLOR
    } kind_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STIP,
        S_FILL,
        S_COPY,
        S_DRAIN
    } state_t;

endpackage

// File: rtl/sbe_decode.sv
module sbe_decode
    import sbe_pkg::*;
#(
    parameter  int PIX_W  = 20,
    parameter  int COL_W  = 8,
    localparam int ADDR_W = PIX_W + ADDR_SHIFT
) (
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_W-1:0]  data,
    output kind_t             kind,
    output logic [PIX_W-1:0]  dst,
    output logic [PIX_W-1:0]  src,
    output logic [LEN_W-1:0]  len_m1,
    output logic [MASK_W-1:0] mask,
    output logic [COL_W-1:0]  color
);

    // Sub-pixel byte bits carry no meaning
    logic unused_low;
    assign unused_low = ^addr[ADDR_SHIFT-1:0];

    assign dst    = addr[ADDR_SHIFT +: PIX_W];
    assign src    = data[PIX_W-1:0];
    assign len_m1 = data[LEN_LSB +: LEN_W];
    assign mask   = data[MASK_W-1:0];
    assign color  = data[COL_W-1:0];

    always_comb begin
        kind = K_SKIP;
        unique case (win_t'(sel))
            WIN_STIP:  kind = (data[MASK_W-1:0] == '0) ? K_SKIP : K_STIP;
            WIN_BLIT:  kind = (data[SRC_W-1:0] == FILL_CODE) ? K_FILL : K_COPY;
            WIN_COLOR: kind = K_COLOR;
            default:   kind = K_SKIP;
        endcase
    end

endmodule

// File: rtl/sbe_seq.sv
module sbe_seq
    import sbe_pkg::*;
#(
    parameter int PIX_W = 20,
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  kind_t             kind,
    input  logic [PIX_W-1:0]  dst,
    input  logic [PIX_W-1:0]  src,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [MASK_W-1:0] mask,
    input  logic [COL_W-1:0]  color_in,
    output logic              cmd_ready,
    output logic              busy,
    output logic              rd_en,
    output logic [PIX_W-1:0]  rd_addr,
    output logic [PIX_W-1:0]  rd_dst,
    output logic              wr_en,
    output logic [PIX_W-1:0]  wr_addr,
    output logic [COL_W-1:0]  fill_color
);

    state_t            state_q, state_d;
    logic [PIX_W-1:0]  cur_q, cur_d;
    logic [PIX_W-1:0]  src_q, src_d;
    logic [LEN_W-1:0]  cnt_q, cnt_d;
    logic [MASK_W-1:0] mask_q, mask_d;
    logic [COL_W-1:0]  color_q, color_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            src_q   <= '0;
            cnt_q   <= '0;
            mask_q  <= '0;
            color_q <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            src_q   <= src_d;
            cnt_q   <= cnt_d;
            mask_q  <= mask_d;
            color_q <= color_d;
        end
    end

    // Next state and datapath
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        src_d   = src_q;
        cnt_d   = cnt_q;
        mask_d  = mask_q;
        color_d = color_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (kind)
                        K_STIP: begin
                            mask_d  = mask;
                            cur_d   = dst;
                            state_d = S_STIP;
                        end
                        K_FILL: begin
                            cur_d   = dst;
                            cnt_d   = len_m1;
                            state_d = S_FILL;
                        end
                        K_COPY: begin
                            cur_d   = dst;
                            src_d   = src;
                            cnt_d   = len_m1;
                            state_d = S_COPY;
                        end
                        K_COLOR: color_d = color_in;
                        default: color_d = color_q;
                    endcase
                end
            end
            S_STIP: begin
                mask_d = {mask_q[MASK_W-2:0], 1'b0};
                cur_d  = cur_q + 1'b1;
                if (mask_q[MASK_W-2:0] == '0) state_d = S_IDLE;
            end
            S_FILL: begin
                cur_d = cur_q + 1'b1;
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == '0) state_d = S_IDLE;
            end
            S_COPY: begin
                cur_d = cur_q + 1'b1;
                src_d = src_q + 1'b1;
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == '0) state_d = S_DRAIN;
            end
            S_DRAIN: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_ready = 1'b0;
        busy      = 1'b1;
        rd_en     = 1'b0;
        wr_en     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                cmd_ready = 1'b1;
                busy      = 1'b0;
            end
            S_STIP:  wr_en = mask_q[MASK_W-1];
            S_FILL:  wr_en = 1'b1;
            S_COPY:  rd_en = 1'b1;
            S_DRAIN: rd_en = 1'b0;
            default: busy  = 1'b1;
        endcase
    end

    assign rd_addr    = src_q;
    assign rd_dst     = cur_q;
    assign wr_addr    = cur_q;
    assign fill_color = color_q;

endmodule

// File: rtl/sbe_copy_pipe.sv
module sbe_copy_pipe #(
    parameter int PIX_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_fire,
    input  logic [PIX_W-1:0] rd_dst,
    output logic             wr_valid,
    output logic [PIX_W-1:0] wr_addr
);

    // Delays the destination by the read latency of the memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
        end else begin
            wr_valid <= rd_fire;
            wr_addr  <= rd_dst;
        end
    end

endmodule

// File: rtl/stip_blit_engine.sv
module stip_blit_engine
    import sbe_pkg::*;
#(
    parameter  int PIX_W  = 20,
    parameter  int COL_W  = 8,
    localparam int ADDR_W = PIX_W + ADDR_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_sel,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    output logic [CMD_W-1:0]  rd_data,
    output logic              busy,
    output logic              mem_re,
    output logic [PIX_W-1:0]  mem_raddr,
    input  logic [COL_W-1:0]  mem_rdata,
    output logic              mem_we,
    output logic [PIX_W-1:0]  mem_waddr,
    output logic [COL_W-1:0]  mem_wdata
);

    kind_t             dec_kind;
    logic [PIX_W-1:0]  dec_dst, dec_src;
    logic [LEN_W-1:0]  dec_len;
    logic [MASK_W-1:0] dec_mask;
    logic [COL_W-1:0]  dec_color;
    logic [PIX_W-1:0]  rd_dst;
    logic              seq_wr;
    logic [PIX_W-1:0]  seq_waddr;
    logic [COL_W-1:0]  fill_color;
    logic              cp_valid;
    logic [PIX_W-1:0]  cp_addr;

    sbe_decode #(.PIX_W(PIX_W), .COL_W(COL_W)) u_decode (
        .sel    (cmd_sel),
        .addr   (cmd_addr),
        .data   (cmd_wdata),
        .kind   (dec_kind),
        .dst    (dec_dst),
        .src    (dec_src),
        .len_m1 (dec_len),
        .mask   (dec_mask),
        .color  (dec_color)
    );

    sbe_seq #(.PIX_W(PIX_W), .COL_W(COL_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .kind       (dec_kind),
        .dst        (dec_dst),
        .src        (dec_src),
        .len_m1     (dec_len),
        .mask       (dec_mask),
        .color_in   (dec_color),
        .cmd_ready  (cmd_ready),
        .busy       (busy),
        .rd_en      (mem_re),
        .rd_addr    (mem_raddr),
        .rd_dst     (rd_dst),
        .wr_en      (seq_wr),
        .wr_addr    (seq_waddr),
        .fill_color (fill_color)
    );

    sbe_copy_pipe #(.PIX_W(PIX_W)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_fire  (mem_re),
        .rd_dst   (rd_dst),
        .wr_valid (cp_valid),
        .wr_addr  (cp_addr)
    );

    assign mem_we    = seq_wr | cp_valid;
    assign mem_waddr = cp_valid ? cp_addr : seq_waddr;
    assign mem_wdata = cp_valid ? mem_rdata : fill_color;
    assign rd_data   = '0;

endmodule

// File: rtl/sbe_checker.sv
module sbe_checker #(
    parameter int PIX_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             busy,
    input logic             mem_re,
    input logic [PIX_W-1:0] mem_raddr,
    input logic             mem_we,
    input logic [PIX_W-1:0] mem_waddr,
    input logic             seq_wr,
    input logic             cp_valid
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    assert_read_then_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> mem_we);

    assert_ascending_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_raddr == $past(mem_raddr) + 1'b1));

    assert_no_write_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_wr && cp_valid));

    assert_busy_from_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid && cmd_ready));

    assert_write_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_waddr == $past(mem_waddr) + 1'b1));

endmodule

bind stip_blit_engine sbe_checker #(.PIX_W(PIX_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .seq_wr    (seq_wr),
    .cp_valid  (cp_valid)
);

// File: tb/tb_stip_blit_engine.sv
`timescale 1ns/1ps
module tb_stip_blit_engine;

    localparam int PIX_W = 12;
    localparam int NPIX  = 1 << PIX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_sel = '0;
    logic [14:0] cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] rd_data;
    logic        busy;
    logic        mem_re, mem_we;
    logic [11:0] mem_raddr, mem_waddr;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  mem_wdata;

    logic [7:0]  mem [NPIX];
    logic [7:0]  ref_mem [NPIX];
    logic [7:0]  ref_color = '0;
    int          wr_events = 0;
    int          tests = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    stip_blit_engine #(.PIX_W(PIX_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_sel(cmd_sel), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rd_data(rd_data), .busy(busy), .mem_re(mem_re), .mem_raddr(mem_raddr),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata)
    );

    // Frame memory model: one cycle read latency
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_waddr] <= mem_wdata;
            wr_events <= wr_events + 1;
        end
        if (mem_re) mem_rdata <= mem[mem_raddr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_busy(input logic [1:0] sel, input logic [31:0] d);
        if (sel == 2'd0) begin
            for (int i = 0; i < 32; i++) if (d[i]) return 32 - i;
            return 0;
        end
        if (sel == 2'd1) begin
            if (d[23:0] == 24'hFFFFFF) return int'(d[28:24]) + 1;
            return int'(d[28:24]) + 2;
        end
        return 0;
    endfunction

    task automatic ref_apply(input logic [1:0] sel, input logic [14:0] addr, input logic [31:0] d);
        int dst = int'(addr >> 3);
        int len = int'(d[28:24]) + 1;
        int s   = int'(d[11:0]);
        case (sel)
            2'd0: for (int i = 0; i < 32; i++)
                      if (d[31-i]) ref_mem[(dst + i) % NPIX] = ref_color;
            2'd1: begin
                if (d[23:0] == 24'hFFFFFF)
                    for (int i = 0; i < len; i++) ref_mem[(dst + i) % NPIX] = ref_color;
                else
                    for (int i = 0; i < len; i++) ref_mem[(dst + i) % NPIX] = ref_mem[(s + i) % NPIX];
            end
            2'd2: ref_color = d[7:0];
            default: ;
        endcase
    endtask

    task automatic mem_compare(input string req);
        int bad = 0;
        for (int i = 0; i < NPIX; i++) if (mem[i] !== ref_mem[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic run_cmd(input logic [1:0] sel, input logic [14:0] addr,
                           input logic [31:0] d, input string req);
        int bc = 0;
        @(negedge clk);
        cmd_sel = sel; cmd_addr = addr; cmd_wdata = d; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        forever begin
            @(negedge clk);
            if (!busy) break;
            bc++;
            if (bc > 100) break;
        end
        ref_apply(sel, addr, d);
        chk(bc == exp_busy(sel, d), {req, " busy length"}, bc, exp_busy(sel, d));
        mem_compare({req, " memory"});
    endtask

    initial begin
        int snap, stall;
        logic [11:0] dpix, spix;
        logic [31:0] dw;
        logic [1:0]  ks;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NPIX; i++) begin
            mem[i]     = 8'($urandom);
            ref_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R1 reset state, R12 zero read data
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
        chk(!mem_we && !mem_re, "R1 strobes", int'({mem_we, mem_re}), 0);
        chk(rd_data == 32'd0, "R12 rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 fill colour resets to 0: stipple before any colour load
        run_cmd(2'd0, {12'd40, 3'd0}, 32'hF000_0000, "R1 reset colour");
        // R9 colour load, R2 low address bits ignored, R3 MSB first
        run_cmd(2'd2, 15'd0, 32'hFFFF_FF5A, "R9 colour");
        run_cmd(2'd0, {12'd100, 3'd5}, 32'hA000_0001, "R3 R2 stipple");
        chk(mem[100] == 8'h5A && mem[101] != 8'h5A || mem[100] == 8'h5A, "R3 first pixel", int'(mem[100]), 'h5A);
        run_cmd(2'd0, {12'd300, 3'd0}, 32'h8000_0000, "R5 single bit");
        // R4 zero mask: no busy, no writes
        snap = wr_events;
        run_cmd(2'd0, {12'd200, 3'd0}, 32'h0, "R4 zero mask");
        chk(wr_events == snap, "R4 write count", wr_events - snap, 0);
        // R11 unused window
        snap = wr_events;
        run_cmd(2'd3, {12'd10, 3'd0}, 32'hFFFF_FFFF, "R11 unused window");
        chk(wr_events == snap, "R11 write count", wr_events - snap, 0);
        run_cmd(2'd0, {12'd500, 3'd0}, 32'h0000_0001, "R11 colour kept");
        // R7 fill, max and min length; R13 wrap
        run_cmd(2'd1, {12'd600, 3'd0}, 32'h1FFF_FFFF, "R7 fill 32");
        run_cmd(2'd1, {12'd700, 3'd0}, 32'h00FF_FFFF, "R7 fill 1");
        run_cmd(2'd1, {12'd4094, 3'd0}, 32'h03FF_FFFF, "R13 wrap fill");
        // R8 copy; R6 high bits ignored and source truncated
        run_cmd(2'd1, {12'd1000, 3'd0}, 32'h0400_0800, "R8 copy 5");
        run_cmd(2'd1, {12'd1100, 3'd0}, 32'hFF12_3900, "R6 copy 32");
        run_cmd(2'd1, {12'd1200, 3'd0}, 32'h0000_0F00, "R8 copy 1");

        // R10 stall while busy
        @(negedge clk);
        cmd_sel = 2'd1; cmd_addr = {12'd1500, 3'd0}; cmd_wdata = 32'h1FFF_FFFF; cmd_valid = 1'b1;
        @(posedge clk);
        #1 cmd_wdata = 32'h0000_0000;
        cmd_sel = 2'd1; cmd_addr = {12'd1600, 3'd0}; cmd_wdata = 32'h1F00_0100;
        ref_apply(2'd1, {12'd1500, 3'd0}, 32'h1FFF_FFFF);
        stall = 0;
        @(negedge clk);
        while (!cmd_ready && stall < 100) begin
            stall++;
            @(negedge clk);
        end
        chk(stall == 32, "R10 stall cycles", stall, 32);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R10 held command started", int'(busy), 1);
        while (busy) @(negedge clk);
        ref_apply(2'd1, {12'd1600, 3'd0}, 32'h1F00_0100);
        mem_compare("R10 memory");

        // Constrained random mix
        for (int n = 0; n < 40; n++) begin
            ks   = 2'($urandom % 4);
            dpix = 12'($urandom);
            case (ks)
                2'd0: begin
                    dw = $urandom;
                    if (($urandom % 3) == 0) dw = dw & $urandom & $urandom;
                    run_cmd(2'd0, {dpix, 3'($urandom)}, dw, "R3 random stipple");
                end
                2'd1: begin
                    spix = 12'((int'(dpix) + 64 + int'($urandom % 3900)) % NPIX);
                    dw = {3'($urandom), 5'($urandom), 1'b0, 11'($urandom), spix};
                    run_cmd(2'd1, {dpix, 3'($urandom)}, dw, "R8 random copy");
                end
                2'd2: begin
                    dw = {3'($urandom), 5'($urandom), 24'hFFFFFF};
                    run_cmd(2'd1, {dpix, 3'($urandom)}, dw, "R7 random fill");
                end
                default: run_cmd(2'd2, 15'($urandom), $urandom, "R9 random colour");
            endcase
        end
        chk(rd_data == 32'd0, "R12 rd_data end", int'(rd_data), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule